// File: doc/BRIEF.md
# Programmable Reference Clock Generator

This block derives a reference clock from its base clock. A power-of-two ratio between 1 and 128 sets the output frequency. A duty selector sets the high time to 0, 25, 50 or 75 percent of the output period. At the two smallest ratios the high time is shaped from the base clock's own level and edges, because there is nothing to count at those ratios. At ratio 4 and above, a period counter sets the high time.

All settings sit in one control word. The word is written and read back through a plain synchronous register port. The port has no handshake and no back-pressure: a write is taken on every clock edge where the write strobe is high, and the read data always reflects the stored word.

Divider and duty changes wait for the end of the running period, so the output never shows a runt pulse. The generated clock passes through an output multiplexer toward a pad. When a chip-level clock-out option is off, the multiplexer sends the base clock divided by four to the pad instead. The slew-limit bit is only stored and passed on to the pad control.

Top module: `refclk_gen`

## Requirements
- R1: The ratio field, bits [2:0] of the control word, selects an output period of 2^N base cycles, for N from 0 to 7.
- R2: The duty field, bits [5:4], selects the high time: 0 = always low, 1 = one quarter, 2 = one half, 3 = three quarters of the period.
- R3: With the clock-out option on, `pad_o` follows `ref_clk_o` when the output-enable bit (bit 7) is 1. When that bit is 0, `pad_o` is low. `pad_oe_o` equals the output-enable bit.
- R4: After reset the control word reads 0x0060: enable, output-enable and ratio are 0, slew-limit is 1, duty is 2. `ref_clk_o` is low.
- R5: At ratio 1 with a nonzero duty, `ref_clk_o` equals the base clock level.
- R6: At ratio 2, duty 2 keeps the output high for the first full base cycle of each period. Duty 1 is high only during the high half of that cycle. Duty 3 is low only during the low half of the second cycle.
- R7: At ratio 4 and above, the output is high for the first quarter, half or three quarters of the base cycles in each period, as the duty field selects.
- R8: A new ratio or duty written while the generator runs takes effect only when the running period completes.
- R9: Clearing the enable bit (bit 8) drives `ref_clk_o` low from the second clock edge after the write on. Setting it starts a fresh period at the second edge after the write, with the high phase first.
- R10: With the clock-out option off, `pad_o` carries the base clock divided by four (two cycles high, two low), and `pad_oe_o` is 1.
- R11: The slew-limit bit (bit 6) is readable and writable and appears unchanged on `slew_o`.
- R12: The read data returns every implemented field. Bit 3 and bits above 8 read as zero, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clkout_en | input | 1 | Chip-level clock-out option; 0 routes the base clock divided by four to the pad |
| wr_en | input | 1 | Control word write strobe |
| wdata | input | DATA_W | Control word write data |
| rdata | output | DATA_W | Control word read data |
| ref_clk_o | output | 1 | Generated reference clock |
| pad_o | output | 1 | Multiplexed pad data |
| pad_oe_o | output | 1 | Pad output enable |
| slew_o | output | 1 | Slew-limit control toward the pad |

## Verification
The bench goes after the ratio-1 and ratio-2 shapes by sampling the output in both halves of every base cycle. A design that counts at those ratios instead of shaping from the clock level shows wrong high halves there. It then changes the ratio and duty partway through a period. A design that applies new settings immediately cuts the running period short, and the bench sees that as a mismatch in the queued pattern.

Each pattern is scored from the exact cycle after enable. A generator that does not restart its period on re-enable, or that begins with the low phase, misses the first item. The bench also checks the extremes: zero duty, ratio 128, the pad with output-enable off, and the divide-by-four fallback. A mux that ignores either control bit is caught at `pad_o`.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int DIV_W    = 3;
  localparam int POS_DIV  = 0;
  localparam int POS_DUTY = 4;
  localparam int POS_SLEW = 6;
  localparam int POS_OE   = 7;
  localparam int POS_EN   = 8;

  typedef enum logic [1:0] {
    DUTY_OFF  = 2'd0,
    DUTY_Q1   = 2'd1,
    DUTY_HALF = 2'd2,
    DUTY_Q3   = 2'd3
  } duty_e;

  typedef struct packed {
    logic             en;
    logic             oe;
    logic             slew;
    duty_e            duty;
    logic [DIV_W-1:0] div;
  } ctrl_t;
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl
);
  localparam logic [DATA_W-1:0] RW_MASK =
      (DATA_W'((1 << DIV_W) - 1) << POS_DIV) | (DATA_W'(3) << POS_DUTY) |
      (DATA_W'(1) << POS_SLEW) | (DATA_W'(1) << POS_OE) | (DATA_W'(1) << POS_EN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl.en   <= 1'b0;
      ctrl.oe   <= 1'b0;
      ctrl.slew <= 1'b1;
      ctrl.duty <= DUTY_HALF;
      ctrl.div  <= '0;
    end else if (wr_en) begin
      ctrl.en   <= wdata[POS_EN];
      ctrl.oe   <= wdata[POS_OE];
      ctrl.slew <= wdata[POS_SLEW];
      ctrl.duty <= duty_e'(wdata[POS_DUTY +: 2]);
      ctrl.div  <= wdata[POS_DIV +: DIV_W];
    end
  end

  always_comb begin
    rdata                    = '0;
    rdata[POS_DIV +: DIV_W]  = ctrl.div;
    rdata[POS_DUTY +: 2]     = ctrl.duty;
    rdata[POS_SLEW]          = ctrl.slew;
    rdata[POS_OE]            = ctrl.oe;
    rdata[POS_EN]            = ctrl.en;
  end

  // R12: a write returns its implemented fields on the next cycle, reserved bits zero
  a_r12_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata == ($past(wdata) & RW_MASK));

  // R11: slew bit holds without a write
  a_r11_slew_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl.slew));
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
  import refclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_req,
  input  duty_e            duty_req,
  output logic             run_q,
  output logic             lvl_q,
  output logic [DIV_W-1:0] act_div,
  output duty_e            act_duty
);
  localparam int CW = (1 << DIV_W) - 1;
  localparam int PW = CW + 1;

  logic [CW-1:0]    cnt_q, cnt_n, last;
  logic             wrap;
  logic [DIV_W-1:0] nxt_div;
  duty_e            nxt_duty;
  logic [PW-1:0]    per, qtr, half, thr;
  logic             lvl_n;

  always_comb begin
    last     = ~({CW{1'b1}} << act_div);
    wrap     = !run_q || (cnt_q == last);
    nxt_div  = wrap ? div_req  : act_div;
    nxt_duty = wrap ? duty_req : act_duty;
    cnt_n    = wrap ? '0 : cnt_q + 1'b1;
    per      = PW'(1) << nxt_div;
    qtr      = per >> 2;
    half     = per >> 1;
    unique case (nxt_duty)
      DUTY_Q1:   thr = qtr;
      DUTY_HALF: thr = half;
      DUTY_Q3:   thr = qtr + half;
      default:   thr = '0;
    endcase
    if (nxt_div < DIV_W'(2) && nxt_duty != DUTY_OFF) thr = PW'(1);
    lvl_n = ({1'b0, cnt_n} < thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      lvl_q    <= 1'b0;
      cnt_q    <= '0;
      act_div  <= '0;
      act_duty <= DUTY_HALF;
    end else if (!en) begin
      run_q    <= 1'b0;
      lvl_q    <= 1'b0;
      cnt_q    <= '0;
      act_div  <= div_req;
      act_duty <= duty_req;
    end else begin
      run_q    <= 1'b1;
      lvl_q    <= lvl_n;
      cnt_q    <= cnt_n;
      act_div  <= nxt_div;
      act_duty <= nxt_duty;
    end
  end

  // R8: running settings move only at a period boundary
  a_r8_change_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !($stable(act_div) && $stable(act_duty))) |-> cnt_q == '0);

  // R7: the period counter stays inside the active period
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q <= last);

  // R9: disabled generator goes low on the next edge
  a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!lvl_q && !run_q));

  // R9: a fresh start begins with the high phase
  a_r9_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !run_q && duty_req != DUTY_OFF) |=> lvl_q);
endmodule

// File: rtl/refclk_shaper.sv
module refclk_shaper
  import refclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             lvl,
  input  logic [DIV_W-1:0] act_div,
  input  duty_e            act_duty,
  input  logic             clkout_cfg,
  input  logic             oe,
  output logic             ref_clk,
  output logic             pad_o,
  output logic             pad_oe
);
  logic [1:0] q4;
  logic       base_div4;

  always_ff @(posedge clk) begin
    if (!rst_n) q4 <= '0;
    else        q4 <= q4 + 2'd1;
  end
  assign base_div4 = q4[1];

  always_comb begin
    if (!run || act_duty == DUTY_OFF) begin
      ref_clk = 1'b0;
    end else if (act_div == '0) begin
      ref_clk = clk;
    end else if (act_div == DIV_W'(1)) begin
      unique case (act_duty)
        DUTY_Q1: ref_clk = lvl & clk;
        DUTY_Q3: ref_clk = lvl | clk;
        default: ref_clk = lvl;
      endcase
    end else begin
      ref_clk = lvl;
    end
  end

  assign pad_o  = clkout_cfg ? (oe & ref_clk) : base_div4;
  assign pad_oe = clkout_cfg ? oe : 1'b1;

  // R10: fallback stays high for exactly two cycles
  a_r10_div4_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (base_div4 && $past(base_div4)) |=> !base_div4);
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clkout_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ref_clk_o,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              slew_o
);
  ctrl_t            ctrl;
  logic             run_q, lvl_q;
  logic [DIV_W-1:0] act_div;
  duty_e            act_duty;

  refclk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .ctrl(ctrl)
  );

  refclk_divider u_div (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .div_req(ctrl.div),
    .duty_req(ctrl.duty), .run_q(run_q), .lvl_q(lvl_q),
    .act_div(act_div), .act_duty(act_duty)
  );

  refclk_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .run(run_q), .lvl(lvl_q),
    .act_div(act_div), .act_duty(act_duty), .clkout_cfg(cfg_clkout_en),
    .oe(ctrl.oe), .ref_clk(ref_clk_o), .pad_o(pad_o), .pad_oe(pad_oe_o)
  );

  assign slew_o = ctrl.slew;

  // R3: with output-enable off and the option on, the pad stays low
  a_r3_pad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clkout_en && !ctrl.oe) |-> (!pad_o && !pad_oe_o));
endmodule

// File: tb/refclk_gen_test.sv
`timescale 1ns/1ps
module refclk_gen_test;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_clkout_en = 1'b1;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              ref_clk_o, pad_o, pad_oe_o, slew_o;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  typedef struct { bit hi; bit lo; string req; } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  refclk_gen #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_clkout_en(cfg_clkout_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ref_clk_o(ref_clk_o), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .slew_o(slew_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [DATA_W-1:0] word(int div, int duty, bit slew, bit oe, bit en);
    return DATA_W'(div) | (DATA_W'(duty) << 4) | (DATA_W'(slew) << 6) |
           (DATA_W'(oe) << 7) | (DATA_W'(en) << 8);
  endfunction

  function automatic exp_t mk(int div, int duty, int j, string req);
    exp_t e;
    int per = 1 << div;
    int thr;
    bit first = ((j % per) == 0);
    e.req = req;
    if (duty == 0) begin e.hi = 0; e.lo = 0; end
    else if (div == 0) begin e.hi = 1; e.lo = 0; end
    else if (div == 1) begin
      case (duty)
        1: begin e.hi = first; e.lo = 0; end
        3: begin e.hi = 1; e.lo = first; end
        default: begin e.hi = first; e.lo = first; end
      endcase
    end else begin
      thr = (duty == 1) ? per / 4 : (duty == 2) ? per / 2 : 3 * per / 4;
      e.hi = ((j % per) < thr);
      e.lo = e.hi;
    end
    return e;
  endfunction

  task automatic wr(logic [DATA_W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push_zeros(int n, string req);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      e.hi = 0; e.lo = 0; e.req = req;
      sbq.push_back(e);
    end
  endtask

  task automatic run_pattern(int div, int duty, int n, string req);
    wr(word(div, duty, 1, 1, 0));
    wr(word(div, duty, 1, 1, 1));
    for (int j = 0; j < n; j++) sbq.push_back(mk(div, duty, j, req));
    drain();
    wr(word(div, duty, 1, 1, 0));
    push_zeros(3, "R9");
    drain();
  endtask

  // monitor: pops one expected item per base cycle, samples both halves
  initial begin
    exp_t cur;
    logic sh, sl;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() != 0) begin
        cur = sbq.pop_front();
        sh = ref_clk_o;
        #2.5;
        sl = ref_clk_o;
        chk(sh == cur.hi, cur.req, "ref_clk_o high half", int'(sh), int'(cur.hi));
        chk(sl == cur.lo, cur.req, "ref_clk_o low half", int'(sl), int'(cur.lo));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic s[24];
    int hits;
    int rise;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 16'h0060, "R4", "reset control word", int'(rdata), 'h60);
    chk(ref_clk_o == 1'b0, "R4", "reset output", int'(ref_clk_o), 0);
    chk(slew_o == 1'b1, "R11", "reset slew", int'(slew_o), 1);

    wr(16'hFFFF);
    chk(rdata == 16'h01F7, "R12", "readback all ones", int'(rdata), 'h1F7);
    wr(16'h0000);
    chk(rdata == 16'h0000, "R12", "readback zero", int'(rdata), 0);
    chk(slew_o == 1'b0, "R11", "slew cleared", int'(slew_o), 0);
    wr(word(0, 2, 1, 0, 0));
    chk(slew_o == 1'b1, "R11", "slew set", int'(slew_o), 1);

    run_pattern(0, 2, 6, "R5");
    run_pattern(0, 1, 4, "R5");
    run_pattern(0, 0, 4, "R2");
    run_pattern(1, 2, 8, "R6");
    run_pattern(1, 1, 8, "R6");
    run_pattern(1, 3, 8, "R6");
    run_pattern(2, 1, 12, "R7");
    run_pattern(3, 3, 16, "R7");
    run_pattern(5, 2, 64, "R1");
    run_pattern(7, 2, 256, "R1");
    run_pattern(4, 0, 32, "R2");

    // R8: change mid-period, old period must complete first
    wr(word(3, 2, 1, 1, 0));
    wr(word(3, 2, 1, 1, 1));
    for (int j = 0; j < 8; j++) sbq.push_back(mk(3, 2, j, "R8"));
    for (int j = 0; j < 8; j++) sbq.push_back(mk(2, 1, j, "R8"));
    wr(word(2, 1, 1, 1, 1));
    drain();
    wr(word(2, 1, 1, 1, 0));
    push_zeros(3, "R9");
    drain();

    // R3: output-enable off keeps the pad quiet while the clock runs
    wr(word(1, 2, 1, 0, 1));
    hits = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (ref_clk_o) hits++;
      chk(pad_o == 1'b0, "R3", "pad low with oe off", int'(pad_o), 0);
    end
    chk(pad_oe_o == 1'b0, "R3", "pad_oe with oe off", int'(pad_oe_o), 0);
    chk(hits > 0, "R3", "generator still runs", hits, 4);
    wr(word(1, 2, 1, 1, 1));
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(pad_o == ref_clk_o, "R3", "pad follows clock", int'(pad_o), int'(ref_clk_o));
    end
    chk(pad_oe_o == 1'b1, "R3", "pad_oe with oe on", int'(pad_oe_o), 1);

    // R10: option off gives base clock divided by four
    cfg_clkout_en = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #1;
      s[i] = pad_o;
    end
    chk(pad_oe_o == 1'b1, "R10", "pad_oe forced", int'(pad_oe_o), 1);
    rise = -1;
    for (int i = 1; i < 8; i++) if (rise < 0 && s[i] && !s[i-1]) rise = i;
    chk(rise >= 0, "R10", "fallback rising edge found", rise, 1);
    if (rise >= 0) begin
      for (int i = 0; i < 12; i++) begin
        chk(s[rise + i] == (((i % 4) < 2) ? 1'b1 : 1'b0), "R10", "fallback shape",
            int'(s[rise + i]), ((i % 4) < 2) ? 1 : 0);
      end
    end
    cfg_clkout_en = 1'b1;
    wr(word(0, 2, 1, 0, 0));
    drain();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule